// File: doc/BRIEF.md
# Chainable Timer with Master Trigger Output

An up-counting timer that drives a single trigger line for chaining to other timers. The counter advances once every `psc_i + 1` enabled clocks. It counts from 0 up to the reload value, then wraps to 0 and raises a one-clock update pulse. Four compare channels each produce a PWM reference level and a sticky match flag.

A 3-bit master-mode field picks what drives the trigger line. The choices are:
- a software clear strobe;
- the effective count enable;
- the update pulse;
- a channel-1 match pulse, which fires even when its flag is already set;
- one of the four reference levels.

The counter runs when the software enable is high, or when gating is active and the gate input is high. Either the software strobe or a slave reset input clears the counter and the prescaler. A downstream timer can use the trigger line as its clock, its gate or its reset.

Top module: `chain_timer`

## Requirements
- R1: After reset the counter and prescaler hold 0. `trgo_o`, `upd_o` and all `cc_flag_o` bits are 0. `ocref_o[i]` equals (0 < compare value i).
- R2: While the effective enable is high, the counter advances by one every `psc_i + 1` clocks. With `psc_i` = 2 and `arr_i` = 5, successive update pulses are 18 clocks apart.
- R3: The counter steps from 0 up to `arr_i`; the step after `arr_i` returns it to 0. `upd_o` is high for exactly the one clock after that wrap step.
- R4: `ug_i` or `slave_rst_i` clears the counter and the prescaler to 0 at the next clock edge. The clear takes priority over a step and suppresses the update pulse and the match pulses.
- R5: The effective enable is `cnt_en_i | (gate_mode_i & gate_i)`. While it is low, the counter and prescaler hold their values.
- R6: With `mms_i` = 0, `trgo_o` = `ug_i` in the same cycle, OR'ed with `slave_rst_i` delayed by one clock.
- R7: With `mms_i` = 1, `trgo_o` follows the effective enable in the same cycle.
- R8: With `mms_i` = 2, `trgo_o` equals `upd_o`.
- R9: With `mms_i` = 3, `trgo_o` is high for one clock after each counting step that lands on compare value 0. This holds even if `cc_flag_o[0]` is already set.
- R10: With `mms_i` = 4, 5, 6 or 7, `trgo_o` equals `ocref_o[0]`, `[1]`, `[2]` or `[3]` respectively.
- R11: `ocref_o[i]` is high while the counter value is below compare value i, where compare value i is `cmp_i[16*i +: 16]`.
- R12: `cc_flag_o[i]` is set by the same match event that drives the R9 pulse (for channel i), and stays set until `cc_clr_i[i]`. If a set and a clear arrive together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en_i | input | 1 | Software count enable |
| gate_mode_i | input | 1 | Gated-enable mode active |
| gate_i | input | 1 | Gating trigger from slave controller |
| ug_i | input | 1 | Software update-generate (clear) strobe |
| slave_rst_i | input | 1 | Reset-mode trigger from slave controller |
| mms_i | input | 3 | Master-mode select for trigger output |
| psc_i | input | PSC_W | Prescaler value (divide by value+1) |
| arr_i | input | CNT_W | Auto-reload value |
| cmp_i | input | 4*CNT_W | Compare values, channel i at bits CNT_W*i |
| cc_clr_i | input | 4 | Per-channel flag clear |
| trgo_o | output | 1 | Master trigger output |
| upd_o | output | 1 | Update event pulse |
| cc_flag_o | output | 4 | Sticky compare match flags |
| ocref_o | output | 4 | Compare reference levels |

## Verification
Different outputs settle at different times relative to the inputs.

Due in the same cycle as the input:
- `trgo_o` in modes 0 and 1.

Due one clock edge after a step or clear:
- `ocref_o`;
- `upd_o`;
- the match pulse;
- the flags.

Due one clock after the slave reset input:
- the slave-reset echo on `trgo_o` in mode 0.

The bench holds a cycle model written from the requirements. It drives inputs just after the falling edge and compares every output 1 ns later, before the next rising edge. It then advances the model by exactly the one edge that follows. Directed measurements time the gap between update pulses, the number of steps from a clear to a reference edge, and repeated match pulses while a flag stays set.

// File: rtl/tmr_trg_pkg.sv
package tmr_trg_pkg;
  localparam int unsigned TMR_NCH = 4;

  typedef enum logic [2:0] {
    MMS_SWCLR   = 3'd0,
    MMS_ENABLE  = 3'd1,
    MMS_UPDATE  = 3'd2,
    MMS_CC1PULS = 3'd3,
    MMS_REF1    = 3'd4,
    MMS_REF2    = 3'd5,
    MMS_REF3    = 3'd6,
    MMS_REF4    = 3'd7
  } mms_e;
endpackage

// File: rtl/tmr_psc.sv
module tmr_psc #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [PSC_W-1:0] div,
  output logic             tick_o,
  output logic [PSC_W-1:0] phase_o
);
  logic [PSC_W-1:0] ph_q;

  function automatic logic [PSC_W-1:0] phase_next(input logic [PSC_W-1:0] ph,
                                                  input logic [PSC_W-1:0] lim);
    return (ph >= lim) ? '0 : ph + 1'b1;
  endfunction

  assign tick_o  = en && (ph_q >= div);
  assign phase_o = ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   ph_q <= '0;
    else if (clr) ph_q <= '0;
    else if (en)  ph_q <= phase_next(ph_q, div);
  end
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] arr,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             step_o,
  output logic             upd_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] top);
    return (c >= top) ? '0 : c + 1'b1;
  endfunction

  assign nxt_o  = cnt_next(cnt_q, arr);
  assign step_o = tick && !clr;
  assign cnt_o  = cnt_q;
  assign upd_o  = upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= nxt_o;
      upd_q <= (cnt_q >= arr);
    end else begin
      upd_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] nxt,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             flag_clr,
  output logic             hit_o,
  output logic             flag_o,
  output logic             ref_o
);
  logic hit_q, flag_q, hit_now;

  function automatic logic ref_level(input logic [CNT_W-1:0] c,
                                     input logic [CNT_W-1:0] v);
    return c < v;
  endfunction

  assign hit_now = step && (nxt == cmp);
  assign hit_o   = hit_q;
  assign flag_o  = flag_q;
  assign ref_o   = ref_level(cnt, cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      hit_q <= hit_now;
      if (hit_now)       flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_trgo_sel.sv
module tmr_trgo_sel
  import tmr_trg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         mms,
  input  logic               ug,
  input  logic               srst,
  input  logic               en_eff,
  input  logic               upd,
  input  logic               cc1_hit,
  input  logic [TMR_NCH-1:0] refs,
  output logic               trgo_o
);
  logic srst_d;

  always_ff @(posedge clk) begin
    if (!rst_n) srst_d <= 1'b0;
    else        srst_d <= srst;
  end

  always_comb begin
    unique case (mms_e'(mms))
      MMS_SWCLR:   trgo_o = ug | srst_d;
      MMS_ENABLE:  trgo_o = en_eff;
      MMS_UPDATE:  trgo_o = upd;
      MMS_CC1PULS: trgo_o = cc1_hit;
      MMS_REF1:    trgo_o = refs[0];
      MMS_REF2:    trgo_o = refs[1];
      MMS_REF3:    trgo_o = refs[2];
      MMS_REF4:    trgo_o = refs[3];
      default:     trgo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import tmr_trg_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_en_i,
  input  logic                     gate_mode_i,
  input  logic                     gate_i,
  input  logic                     ug_i,
  input  logic                     slave_rst_i,
  input  logic [2:0]               mms_i,
  input  logic [PSC_W-1:0]         psc_i,
  input  logic [CNT_W-1:0]         arr_i,
  input  logic [TMR_NCH*CNT_W-1:0] cmp_i,
  input  logic [TMR_NCH-1:0]       cc_clr_i,
  output logic                     trgo_o,
  output logic                     upd_o,
  output logic [TMR_NCH-1:0]       cc_flag_o,
  output logic [TMR_NCH-1:0]       ocref_o
);
  logic               en_eff, clr, tick, step;
  logic [PSC_W-1:0]   psc_ph;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic [TMR_NCH-1:0] hit;

  assign en_eff = cnt_en_i | (gate_mode_i & gate_i);
  assign clr    = ug_i | slave_rst_i;

  tmr_psc #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en_eff), .div(psc_i),
    .tick_o(tick), .phase_o(psc_ph)
  );

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .arr(arr_i),
    .cnt_o(cnt_q), .nxt_o(cnt_nxt), .step_o(step), .upd_o(upd_o)
  );

  for (genvar g = 0; g < TMR_NCH; g++) begin : g_ch
    tmr_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .step(step), .nxt(cnt_nxt), .cnt(cnt_q),
      .cmp(cmp_i[g*CNT_W +: CNT_W]), .flag_clr(cc_clr_i[g]),
      .hit_o(hit[g]), .flag_o(cc_flag_o[g]), .ref_o(ocref_o[g])
    );
  end

  tmr_trgo_sel u_sel (
    .clk(clk), .rst_n(rst_n), .mms(mms_i), .ug(ug_i), .srst(slave_rst_i),
    .en_eff(en_eff), .upd(upd_o), .cc1_hit(hit[0]), .refs(ocref_o),
    .trgo_o(trgo_o)
  );
endmodule

// File: rtl/tmr_trg_chk.sv
module tmr_trg_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ug_i,
  input logic             slave_rst_i,
  input logic [2:0]       mms_i,
  input logic [3:0]       cc_clr_i,
  input logic             trgo_o,
  input logic             upd_o,
  input logic [3:0]       cc_flag_o,
  input logic [3:0]       ocref_o,
  input logic             en_eff,
  input logic             clr,
  input logic             tick,
  input logic [3:0]       hit,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PSC_W-1:0] psc_ph
);
  p_psc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> psc_ph == '0);
  p_upd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> cnt_q == '0);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && psc_ph == '0 && !upd_o));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_eff && !clr) |=> ($stable(cnt_q) && $stable(psc_ph)));
  p_swclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mms_i == 3'd0 && ug_i) |-> trgo_o);
  p_srst_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mms_i == 3'd0 && $past(slave_rst_i)) |-> trgo_o);
  p_upd_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mms_i == 3'd2) |-> (trgo_o == upd_o));
  p_pulse_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mms_i == 3'd3 && trgo_o) |-> cc_flag_o[0]);
  p_ref_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mms_i[2] |-> (trgo_o == ocref_o[mms_i[1:0]]));
  p_flag_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> cc_flag_o[0]);
  p_flag_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cc_flag_o[1]) |-> $past(cc_clr_i[1]));
endmodule

bind chain_timer tmr_trg_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ug_i(ug_i), .slave_rst_i(slave_rst_i),
  .mms_i(mms_i), .cc_clr_i(cc_clr_i), .trgo_o(trgo_o), .upd_o(upd_o),
  .cc_flag_o(cc_flag_o), .ocref_o(ocref_o), .en_eff(en_eff), .clr(clr),
  .tick(tick), .hit(hit), .cnt_q(cnt_q), .psc_ph(psc_ph)
);

// File: tb/tb_chain_timer.sv
`timescale 1ns/1ps
module tb_chain_timer;
  localparam int CW = 16;
  localparam int PW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, gmode = 0, gate = 0, ug = 0, srst = 0;
  logic [2:0] mms = 0;
  logic [PW-1:0] psc = 0;
  logic [CW-1:0] arr = 0;
  logic [4*CW-1:0] cmp = 0;
  logic [3:0] cclr = 0;
  logic trgo, upd;
  logic [3:0] flag, oref;

  chain_timer #(.CNT_W(CW), .PSC_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .gate_mode_i(gmode),
    .gate_i(gate), .ug_i(ug), .slave_rst_i(srst), .mms_i(mms), .psc_i(psc),
    .arr_i(arr), .cmp_i(cmp), .cc_clr_i(cclr), .trgo_o(trgo), .upd_o(upd),
    .cc_flag_o(flag), .ocref_o(oref)
  );

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  int m_ph = 0, m_cnt = 0;
  bit m_upd = 0, m_srd = 0;
  bit [3:0] m_hit = 0, m_flag = 0;

  function automatic int cmpv(int i);
    return int'(cmp[i*CW +: CW]);
  endfunction

  function automatic bit eff_en();
    return cnt_en | (gmode & gate);
  endfunction

  function automatic bit [3:0] exp_ref();
    bit [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = (m_cnt < cmpv(i));
    return r;
  endfunction

  function automatic bit exp_trgo();
    case (mms)
      3'd0: return ug | m_srd;
      3'd1: return eff_en();
      3'd2: return m_upd;
      3'd3: return m_hit[0];
      default: return exp_ref()[mms[1:0]];
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic string trgo_req();
    case (mms)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model_edge();
    bit clr, en, tk;
    int nxt;
    bit [3:0] h;
    clr = ug | srst; en = eff_en(); tk = en && (m_ph >= int'(psc));
    h = 0;
    m_srd = srst;
    if (clr) begin
      m_ph = 0; m_cnt = 0; m_upd = 0;
    end else begin
      if (en) m_ph = (m_ph >= int'(psc)) ? 0 : m_ph + 1;
      if (tk) begin
        nxt = (m_cnt >= int'(arr)) ? 0 : m_cnt + 1;
        m_upd = (m_cnt >= int'(arr));
        for (int i = 0; i < 4; i++) h[i] = (nxt == cmpv(i));
        m_cnt = nxt;
      end else m_upd = 0;
    end
    for (int i = 0; i < 4; i++)
      if (h[i]) m_flag[i] = 1; else if (cclr[i]) m_flag[i] = 0;
    m_hit = h;
  endtask

  // inputs already applied after a falling edge; check, then cross one rising edge
  task automatic step();
    #1;
    chk(trgo_req(), "trgo", trgo, exp_trgo());
    chk("R3", "upd", upd, m_upd);
    chk("R11", "ocref", oref, exp_ref());
    chk("R12", "flag", flag, m_flag);
    model_edge();
    @(negedge clk);
  endtask

  task automatic pulse_ug();
    ug = 1; step(); ug = 0;
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int last, gap, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "trgo", trgo, 0); chk("R1", "upd", upd, 0);
    chk("R1", "flag", flag, 0); chk("R1", "ocref zero cmp", oref, 0);
    cmp = {16'd5, 16'd5, 16'd5, 16'd5};
    #1 chk("R1", "ocref cmp5", oref, 4'hf);
    @(negedge clk);

    // R2 / R3: gap between update pulses with psc=2, arr=5
    psc = 2; arr = 5; mms = 3'd2; cnt_en = 1;
    pulse_ug();
    last = -1; gap = 0;
    for (int k = 0; k < 60; k++) begin
      #0.5;
      if (upd) begin
        if (last >= 0 && gap == 0) gap = k - last;
        last = k;
      end
      step();
    end
    chk("R2", "update period", gap, 18);

    // R4: clear then reference falls 3 steps later
    psc = 0; arr = 9; cmp = {16'd8, 16'd7, 16'd3, 16'd2}; mms = 3'd5;
    for (int k = 0; k < 5; k++) step();
    pulse_ug();
    n = 0;
    while (oref[1] && n < 20) begin step(); n++; end
    chk("R4", "steps from ug to ref1 low", n, 3);
    srst = 1; mms = 3'd0; step(); srst = 0;
    #1 chk("R6", "delayed slave reset on trgo", trgo, 1);
    n = 0;
    while (oref[1] && n < 20) begin step(); n++; end
    chk("R4", "steps from slave reset to ref1 low", n, 3);

    // R5 / R7: gated enable
    mms = 3'd1; cnt_en = 0; gmode = 1; gate = 0;
    for (int k = 0; k < 4; k++) step();
    #1 chk("R5", "trgo with gate low", trgo, 0);
    chk("R5", "ocref held", oref, exp_ref());
    gate = 1;
    #1 chk("R7", "trgo with gate high", trgo, 1);
    for (int k = 0; k < 4; k++) step();
    gmode = 0;
    #1 chk("R5", "gate ignored outside gated mode", trgo, 0);
    for (int k = 0; k < 3; k++) step();

    // R9: repeated match pulses while flag stays set
    cnt_en = 1; gate = 0; mms = 3'd3; arr = 3; cmp[CW-1:0] = 16'd2;
    pulse_ug();
    n = 0;
    for (int k = 0; k < 16; k++) begin
      #0.5; if (trgo) n++;
      step();
    end
    chk("R9", "pulses in 16 clocks", n, 4);
    #1 chk("R9", "flag still set", flag[0], 1);

    // R10 / R12: reference routing and flag clear
    for (int md = 4; md < 8; md++) begin
      mms = 3'(md);
      for (int k = 0; k < 6; k++) step();
    end
    cclr = 4'hf; step(); cclr = 0;
    for (int k = 0; k < 6; k++) step();

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      if (k % 200 == 0) begin
        psc = PW'($urandom_range(0, 3));
        arr = CW'($urandom_range(0, 12));
        for (int i = 0; i < 4; i++) cmp[i*CW +: CW] = CW'($urandom_range(0, 14));
      end
      if (k % 37 == 0) mms = 3'($urandom_range(0, 7));
      cnt_en = ($urandom_range(0, 9) < 7);
      gmode  = $urandom_range(0, 1);
      gate   = $urandom_range(0, 1);
      ug     = ($urandom_range(0, 49) == 0);
      srst   = ($urandom_range(0, 49) == 0);
      cclr   = 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) == 0}};
      step();
    end
    ug = 0; srst = 0; cclr = 0;
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule